// File: doc/BRIEF.md
# Accumulator Readout Converter

This block turns a 48-bit multiply-accumulate sum into a value that can be written to a 32-bit general register. A set of mode inputs selects how the sum is read.

- Fractional or integer interpretation of the sum.
- Signed or unsigned interpretation in integer mode.
- A 16-bit or 32-bit fractional result.
- Rounding or truncation of the discarded low bits for 32-bit fractional results.
- Whether results that do not fit are clamped.

The conversion logic is purely combinational. A parameter adds one output register stage.

The sum is always treated as a sign-extended 48-bit quantity. Fractional readout drops low bits and can round to the nearest value, with ties going to the even result. The result is then checked against the signed range of the target width.

Top module: `emac_readout`

## Requirements
- R1: In fractional 16-bit mode (`frac_i`=1, `half_i`=1), the value is bits [47:24] of the sum taken as signed and the remainder is bits [23:0]. This mode always rounds, whatever `rnd_i` is. A remainder above 0x800000 adds one to the value.
- R2: In fractional 16-bit mode, a remainder of exactly 0x800000 adds one only when the value's bit 0 is one. A remainder below 0x800000 leaves the value unchanged.
- R3: In fractional 32-bit mode (`half_i`=0) with `rnd_i`=1, the value is the signed sum shifted right by 8 and the remainder is bits [7:0]. A remainder above 0x80 adds one. A remainder of exactly 0x80 adds one only when the value is odd.
- R4: In fractional 32-bit mode with `rnd_i`=0, the value is the signed sum shifted right by 8 with no rounding.
- R5: In fractional 16-bit mode with `sat_i`=1, a rounded value outside the signed 16-bit range gives 0x00007fff when positive and 0x00008000 when negative. An in-range value gives its 16 low bits. In this mode the result's bits [31:16] are always zero.
- R6: In fractional 32-bit mode with `sat_i`=1, a value outside the signed 32-bit range gives 0x7fffffff when positive and 0x80000000 when negative.
- R7: With `sat_i`=0, fractional readout returns the low 16 bits (zero-extended) or the low 32 bits of the rounded value, with no clamping.
- R8: In signed integer mode (`frac_i`=0, `uns_i`=0), a sum inside the signed 32-bit range passes through unchanged. A larger positive sum gives 0x7fffffff and a more negative sum gives 0x80000000. This mode ignores `sat_i`.
- R9: In unsigned integer mode (`frac_i`=0, `uns_i`=1), a sum whose bits [47:32] are zero passes its low 32 bits through. Any other sum gives 0xffffffff.
- R10: With `OUT_REG`=1, the result appears one clock after the inputs and reads zero while reset is held. With `OUT_REG`=0, the result follows the inputs in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output stage |
| rst_n | input | 1 | Active-low synchronous reset of the output stage |
| acc_i | input | ACC_W | Accumulator sum to convert |
| frac_i | input | 1 | 1: fractional readout, 0: integer readout |
| uns_i | input | 1 | Integer readout: 1 unsigned, 0 signed |
| half_i | input | 1 | Fractional readout: 1 gives a 16-bit result |
| rnd_i | input | 1 | 32-bit fractional readout: 1 rounds, 0 truncates |
| sat_i | input | 1 | Fractional readout: 1 clamps out-of-range values |
| res_o | output | WORD_W | Converted result |

## Verification
The bench builds two copies at the default widths: one with `OUT_REG`=1 and one with `OUT_REG`=0. Both are driven from the same stimulus.

The combinational copy is checked in the same cycle the inputs are driven. The registered copy is checked to still hold the previous result before the clock edge and to show the new one after it. This brings the latency rule within reach alongside every conversion mode.

The widths stay at their defaults so that the fixed tie points apply: 0x800000 in 16-bit mode and 0x80 in 32-bit mode. The bench sweeps the 32-bit remainder around 0x80 for both odd and even values. It also checks the cases where rounding alone pushes a value past its limit.

// File: rtl/emac_readout.sv
module emac_readout #(
  parameter int ACC_W   = 48,
  parameter int WORD_W  = 32,
  parameter int HALF_W  = 16,
  parameter int HALF_SH = 24,
  parameter int WORD_SH = 8,
  parameter bit OUT_REG = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ACC_W-1:0]  acc_i,
  input  logic              frac_i,
  input  logic              uns_i,
  input  logic              half_i,
  input  logic              rnd_i,
  input  logic              sat_i,
  output logic [WORD_W-1:0] res_o
);
  localparam int EW  = ACC_W + 1;
  localparam int HTW = EW - HALF_W + 1;
  localparam int WTW = EW - WORD_W + 1;
  localparam int ITW = ACC_W - WORD_W + 1;

  logic signed [EW-1:0] acc_sx;
  assign acc_sx = {acc_i[ACC_W-1], acc_i};

  logic signed [EW-1:0] hv, hr;
  logic [HALF_SH-1:0]   hrem;
  logic                 hinc;
  logic [HTW-1:0]       htop;
  logic                 hfit;
  logic [HALF_W-1:0]    hout;

  assign hv   = acc_sx >>> HALF_SH;
  assign hrem = acc_i[HALF_SH-1:0];
  assign hinc = hrem[HALF_SH-1] & ((|hrem[HALF_SH-2:0]) | hv[0]);
  assign hr   = hv + {{(EW-1){1'b0}}, hinc};
  assign htop = hr[EW-1:HALF_W-1];
  assign hfit = (htop == '0) | (&htop);
  assign hout = (sat_i && !hfit) ? {hr[EW-1], {(HALF_W-1){~hr[EW-1]}}} : hr[HALF_W-1:0];

  logic signed [EW-1:0] wv, wr;
  logic [WORD_SH-1:0]   wrem;
  logic                 winc;
  logic [WTW-1:0]       wtop;
  logic                 wfit;
  logic [WORD_W-1:0]    wout;

  assign wv   = acc_sx >>> WORD_SH;
  assign wrem = acc_i[WORD_SH-1:0];
  assign winc = rnd_i & wrem[WORD_SH-1] & ((|wrem[WORD_SH-2:0]) | wv[0]);
  assign wr   = wv + {{(EW-1){1'b0}}, winc};
  assign wtop = wr[EW-1:WORD_W-1];
  assign wfit = (wtop == '0) | (&wtop);
  assign wout = (sat_i && !wfit) ? {wr[EW-1], {(WORD_W-1){~wr[EW-1]}}} : wr[WORD_W-1:0];

  logic [ITW-1:0]    itop;
  logic              ifit, uhi;
  logic [WORD_W-1:0] sout, uout;

  assign itop = acc_i[ACC_W-1:WORD_W-1];
  assign ifit = (itop == '0) | (&itop);
  assign sout = ifit ? acc_i[WORD_W-1:0] : {acc_i[ACC_W-1], {(WORD_W-1){~acc_i[ACC_W-1]}}};
  assign uhi  = |acc_i[ACC_W-1:WORD_W];
  assign uout = uhi ? '1 : acc_i[WORD_W-1:0];

  logic [WORD_W-1:0] nxt;
  always_comb begin
    if (frac_i) nxt = half_i ? {{(WORD_W-HALF_W){1'b0}}, hout} : wout;
    else        nxt = uns_i ? uout : sout;
  end

  generate
    if (OUT_REG) begin : g_reg
      logic [WORD_W-1:0] q;
      always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= nxt;
      end
      assign res_o = q;
    end else begin : g_comb
      assign res_o = nxt;
    end
  endgenerate
endmodule

// File: rtl/emac_readout_chk.sv
module emac_readout_chk #(
  parameter int ACC_W   = 48,
  parameter int WORD_W  = 32,
  parameter int HALF_W  = 16,
  parameter int WORD_SH = 8,
  parameter bit OUT_REG = 1'b1
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ACC_W-1:0]  acc_i,
  input logic              frac_i,
  input logic              uns_i,
  input logic              half_i,
  input logic              rnd_i,
  input logic              sat_i,
  input logic [WORD_W-1:0] res_o
);
  logic             armed;
  logic [ACC_W-1:0] d_acc;
  logic [4:0]       d_md;

  always_ff @(posedge clk) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;
    d_acc <= acc_i;
    d_md  <= {frac_i, uns_i, half_i, rnd_i, sat_i};
  end

  logic [ACC_W-1:0] a;
  logic f, u, h, r, s;
  assign a = OUT_REG ? d_acc : acc_i;
  assign {f, u, h, r, s} = OUT_REG ? d_md : {frac_i, uns_i, half_i, rnd_i, sat_i};

  logic [ACC_W-WORD_W:0] itop;
  logic [ACC_W-WORD_W-WORD_SH:0] wtop;
  assign itop = a[ACC_W-1:WORD_W-1];
  assign wtop = a[ACC_W-1:WORD_W+WORD_SH-1];

  a_r9_uns_clamp: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && !f && u && (|a[ACC_W-1:WORD_W])) |-> (res_o == '1));

  a_r8_sgn_pass: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && !f && !u && ((itop == '0) || (&itop))) |-> (res_o == a[WORD_W-1:0]));

  a_r5_half_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && f && h) |-> (res_o[WORD_W-1:HALF_W] == '0));

  a_r4_trunc: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && f && !h && !r && !s) |-> (res_o == a[WORD_W+WORD_SH-1:WORD_SH]));

  a_r6_word_clamp: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && f && !h && s && !((wtop == '0) || (&wtop)))
    |-> (res_o == {a[ACC_W-1], {(WORD_W-1){~a[ACC_W-1]}}}));

  generate
    if (OUT_REG) begin : g_rst
      a_r10_reset_zero: assert property (@(posedge clk) !rst_n |=> (res_o == '0));
    end
  endgenerate
endmodule

bind emac_readout emac_readout_chk #(
  .ACC_W(ACC_W), .WORD_W(WORD_W), .HALF_W(HALF_W), .WORD_SH(WORD_SH), .OUT_REG(OUT_REG)
) u_chk (
  .clk(clk), .rst_n(rst_n), .acc_i(acc_i), .frac_i(frac_i), .uns_i(uns_i),
  .half_i(half_i), .rnd_i(rnd_i), .sat_i(sat_i), .res_o(res_o)
);

// File: tb/test_emac_readout.sv
module test_emac_readout;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [47:0] acc = '0;
  logic        frac = 1'b0, uns = 1'b0, half = 1'b0, rnd = 1'b0, sat = 1'b0;
  logic [31:0] res_r, res_c;
  logic [31:0] prev = '0;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  emac_readout #(.OUT_REG(1'b1)) i_emac_readout (
    .clk(clk), .rst_n(rst_n), .acc_i(acc), .frac_i(frac), .uns_i(uns),
    .half_i(half), .rnd_i(rnd), .sat_i(sat), .res_o(res_r));

  emac_readout #(.OUT_REG(1'b0)) i_emac_readout_comb (
    .clk(clk), .rst_n(rst_n), .acc_i(acc), .frac_i(frac), .uns_i(uns),
    .half_i(half), .rnd_i(rnd), .sat_i(sat), .res_o(res_c));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  // mode order: frac uns half rnd sat
  task automatic run(input string tag, input logic [47:0] a, input logic [4:0] md,
                     input logic [31:0] exp);
    @(negedge clk);
    acc = a;
    {frac, uns, half, rnd, sat} = md;
    #1;
    chk({tag, " comb"}, res_c, exp);
    chk("R10 reg holds before edge", res_r, prev);
    @(negedge clk);
    chk({tag, " reg"}, res_r, exp);
    prev = exp;
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk("R10 reset zero", res_r, 32'h0);
    rst_n = 1'b1;
  endtask

  task automatic t_half_round;
    run("R1 above half", 48'h001234_800001, 5'b10100, 32'h1235);
    run("R1 rnd_i ignored", 48'h001234_800001, 5'b10110, 32'h1235);
    run("R2 tie even", 48'h001234_800000, 5'b10100, 32'h1234);
    run("R2 tie odd", 48'h001235_800000, 5'b10100, 32'h1236);
    run("R2 below half", 48'h001235_7fffff, 5'b10100, 32'h1235);
  endtask

  task automatic t_word_round;
    run("R3 above half", 48'h0012345678_81, 5'b10010, 32'h12345679);
    run("R3 tie even", 48'h0012345678_80, 5'b10010, 32'h12345678);
    run("R3 tie odd", 48'h0012345679_80, 5'b10010, 32'h1234567a);
    run("R3 below half", 48'h0012345679_7f, 5'b10010, 32'h12345679);
    run("R4 truncate", 48'h0012345679_ff, 5'b10000, 32'h12345679);
    for (int lsb = 0; lsb < 2; lsb++)
      for (int rm = 8'h7c; rm <= 8'h84; rm++) begin
        logic [31:0] v;
        v = 32'h00abcd10 | 32'(lsb);
        run("R3 sweep", {8'h00, v, 8'(rm)}, 5'b10010,
            v + 32'((rm > 8'h80) || (rm == 8'h80 && lsb == 1)));
        run("R4 sweep", {8'h00, v, 8'(rm)}, 5'b10000, v);
      end
  endtask

  task automatic t_sat;
    run("R5 pos clamp", 48'h012345_000000, 5'b10101, 32'h00007fff);
    run("R5 neg clamp", 48'hfe0000_000000, 5'b10101, 32'h00008000);
    run("R5 in range neg", 48'hffff80_000000, 5'b10101, 32'h0000ff80);
    run("R5 round overflow", 48'h007fff_800000, 5'b10101, 32'h00007fff);
    run("R6 pos clamp", 48'h0100_0000_0000, 5'b10001, 32'h7fffffff);
    run("R6 neg clamp", 48'h8000_0000_0000, 5'b10001, 32'h80000000);
    run("R6 round overflow", 48'h007fffffff_80, 5'b10011, 32'h7fffffff);
  endtask

  task automatic t_wrap;
    run("R7 half wrap", 48'h012345_000000, 5'b10100, 32'h00002345);
    run("R7 half round wrap", 48'h007fff_800000, 5'b10100, 32'h00008000);
    run("R7 word wrap", 48'h0100_0000_0000, 5'b10000, 32'h00000000);
  endtask

  task automatic t_int;
    run("R8 max pass", 48'h0000_7fff_ffff, 5'b00000, 32'h7fffffff);
    run("R8 min pass", 48'hffff_8000_0000, 5'b00000, 32'h80000000);
    run("R8 pos clamp", 48'h0000_8000_0000, 5'b00000, 32'h7fffffff);
    run("R8 neg clamp sat ignored", 48'hfffe_0000_0000, 5'b00001, 32'h80000000);
    run("R9 pass", 48'h0000_dead_beef, 5'b01000, 32'hdeadbeef);
    run("R9 upper set", 48'h0001_0000_0000, 5'b01000, 32'hffffffff);
    run("R9 negative", 48'hffff_ffff_ffff, 5'b01000, 32'hffffffff);
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog actual hung expected done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    t_reset();
    t_half_round();
    t_word_round();
    t_sat();
    t_wrap();
    t_int();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule